// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a watchdog peripheral with three 16-bit registers on a simple word-wide register bus. Software arms it by loading an 8-bit count, choosing a prescaler setting and turning on watchdog mode with the timer enabled. From then on the count climbs by one on every prescaled tick. Software must reload the count often enough that it never passes 255. If it does pass 255, the block records an overflow flag and, when reset generation is enabled, drives a system reset pulse of fixed length.

Each register accepts a write only when the upper byte of the word holds that register's own key. Writes with any other upper byte leave the block unchanged. The overflow flag is hard to clear by accident. Two steps are needed: a read of the reset control/status register that returns the flag set, and then a write of one exact clear word. The flag and the reset-enable bit keep their values through the block's own reset pulse. Only the power-on reset input clears them.

Top module: `keyed_wdog`

## Requirements
- R1: After power-on reset, every readable field is zero and `wdog_rst` is low.
- R2: A write to offset 0 with upper byte 0xA5 loads the mode bit from bit 6, the enable bit from bit 5 and the prescaler select from the low SEL_W bits. Any other upper byte is ignored. A read of offset 0 returns the same fields in the same bit positions, with zeros elsewhere.
- R3: A write to offset 2 with upper byte 0x5A loads the low byte into the count. Any other upper byte is ignored. A read of offset 2 returns the count in bits 7:0.
- R4: A write to offset 4 with upper byte 0x5A loads reset-enable from bit 6. A read of offset 4 returns reset-enable at bit 6 and the overflow flag at bit 7. Other writes to offset 4 leave reset-enable unchanged.
- R5: Select value k divides the clock by 2^(k*MAX_LOG2/(2^SEL_W-1)). With the default 3-bit select this is 4^k. When the count is loaded with c and the timer is enabled, overflow happens exactly (256-c)*divisor clocks after the enabling write.
- R6: While the enable bit is clear, the count holds its value.
- R7: Reloading the count while the timer runs restarts the interval, so regular reloads prevent any overflow.
- R8: An overflow sets the overflow flag only when the mode bit is set. With the mode bit clear, the count wraps and nothing else happens.
- R9: An overflow with both the mode bit and reset-enable set drives `wdog_rst` high for exactly PULSE_LEN clocks, starting the clock after the overflow. The same overflow clears the enable bit and the count, and keeps the overflow flag and reset-enable.
- R10: The overflow flag clears only on a write of exactly 0xA500 to offset 4, and only if an earlier read of offset 4 returned the flag set. Every 0xA500 write cancels that earlier read, so each clear needs a new read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_rd | input | 1 | Read strobe; read data is valid after the edge |
| bus_addr | input | ADDR_W | Byte offset: 0, 2 or 4 |
| bus_wdata | input | 16 | Write word, key in the upper byte |
| bus_rdata | output | 16 | Registered read data |
| wdog_rst | output | 1 | System reset pulse |

## Verification
The checker runs on every cycle. It confirms that the reset pulse lasts exactly PULSE_LEN clocks and that its rising edge always comes with a set flag and a cleared enable bit. It also confirms that the flag only falls right after the exact clear word, that reset-enable changes only on a keyed write, and that the count stays frozen while the timer is disabled. Other behaviours can only be shown by the bench's scenarios: the overflow latency for every select value and several load values, rejection of wrong keys, the read-before-clear sequence, mode 0 leaving the flag alone, and keepalive reloads that hold off the reset.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int WORD_W = 16;
  localparam int CNT_W  = 8;
  localparam logic [7:0]  KEY_CTRL  = 8'hA5;
  localparam logic [7:0]  KEY_CNT   = 8'h5A;
  localparam logic [7:0]  KEY_RST   = 8'h5A;
  localparam logic [15:0] CLR_WORD  = 16'hA500;
  localparam int OFS_CTRL = 0;
  localparam int OFS_CNT  = 2;
  localparam int OFS_RST  = 4;

  // divider exponent for select value k, spread over the select range
  function automatic int div_shift(input int k, input int max_log, input int top_sel);
    return (k * max_log) / top_sel;
  endfunction
endpackage

// File: rtl/kwd_prescaler.sv
module kwd_prescaler #(
  parameter int SEL_W    = 3,
  parameter int MAX_LOG2 = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NSEL = 1 << SEL_W;

  logic [MAX_LOG2-1:0] presc_q;
  logic [NSEL-1:0]     hit;

  always_ff @(posedge clk) begin
    if (rst || !run) presc_q <= '0;
    else             presc_q <= presc_q + 1'b1;
  end

  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    localparam int S = kwd_pkg::div_shift(g, MAX_LOG2, NSEL - 1);
    if (S == 0) begin : g_full
      assign hit[g] = 1'b1;
    end else begin : g_div
      assign hit[g] = &presc_q[S-1:0];
    end
  end

  assign tick = run & hit[sel];
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       clr,
  output logic [7:0] cnt,
  output logic       ovf
);
  logic [7:0] cnt_q;

  assign ovf = tick & (&cnt_q) & ~load;
  assign cnt = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/kwd_regs.sv
module kwd_regs #(
  parameter int SEL_W  = 3,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic [7:0]        cnt,
  input  logic              flag_set,
  input  logic              dog_bite,
  output logic [15:0]       rdata,
  output logic              mode,
  output logic              en,
  output logic [SEL_W-1:0]  sel,
  output logic              rste,
  output logic              flag,
  output logic              cnt_load,
  output logic [7:0]        cnt_val
);
  import kwd_pkg::*;
  localparam int PAD_W = 5 - SEL_W;

  logic [7:0] key;
  logic       hit_ctrl, hit_cnt, hit_rst;
  logic       armed_q;
  logic [7:0] ctrl_view, rst_view;

  assign key      = wdata[15:8];
  assign hit_ctrl = (addr == ADDR_W'(OFS_CTRL));
  assign hit_cnt  = (addr == ADDR_W'(OFS_CNT));
  assign hit_rst  = (addr == ADDR_W'(OFS_RST));
  assign cnt_load = wr & hit_cnt & (key == KEY_CNT);
  assign cnt_val  = wdata[7:0];

  assign ctrl_view = {1'b0, mode, en, {PAD_W{1'b0}}, sel};
  assign rst_view  = {flag, rste, 6'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= 1'b0;
      en      <= 1'b0;
      sel     <= '0;
      rste    <= 1'b0;
      flag    <= 1'b0;
      armed_q <= 1'b0;
      rdata   <= '0;
    end else begin
      if (wr && hit_ctrl && key == KEY_CTRL) begin
        mode <= wdata[6];
        en   <= wdata[5];
        sel  <= wdata[SEL_W-1:0];
      end
      if (dog_bite) en <= 1'b0;
      if (wr && hit_rst && key == KEY_RST) rste <= wdata[6];
      if (wr && hit_rst && wdata == CLR_WORD) begin
        if (armed_q) flag <= 1'b0;
        armed_q <= 1'b0;
      end
      if (rd && hit_rst && flag) armed_q <= 1'b1;
      if (flag_set) flag <= 1'b1;
      if (rd) begin
        if (hit_ctrl)     rdata <= {8'h00, ctrl_view};
        else if (hit_cnt) rdata <= {8'h00, cnt};
        else if (hit_rst) rdata <= {8'h00, rst_view};
        else              rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/kwd_pulse.sv
module kwd_pulse #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      pulse  <= 1'b0;
    end else if (fire) begin
      left_q <= PW'(PULSE_LEN);
      pulse  <= 1'b1;
    end else begin
      if (left_q != '0) left_q <= left_q - 1'b1;
      pulse <= (left_q > PW'(1));
    end
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
  parameter int SEL_W     = 3,
  parameter int MAX_LOG2  = 14,
  parameter int PULSE_LEN = 4,
  parameter int ADDR_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              wdog_rst
);
  logic             mode_q, en_q, rste_q, flag_q;
  logic [SEL_W-1:0] sel_q;
  logic [7:0]       cnt_q, cnt_val;
  logic             cnt_load, tick, ovf, flag_set, dog_bite;

  assign flag_set = ovf & mode_q;
  assign dog_bite = ovf & mode_q & rste_q;

  kwd_regs #(.SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .cnt(cnt_q), .flag_set(flag_set), .dog_bite(dog_bite),
    .rdata(bus_rdata), .mode(mode_q), .en(en_q), .sel(sel_q), .rste(rste_q),
    .flag(flag_q), .cnt_load(cnt_load), .cnt_val(cnt_val)
  );

  kwd_prescaler #(.SEL_W(SEL_W), .MAX_LOG2(MAX_LOG2)) u_presc (
    .clk(clk), .rst(rst), .run(en_q), .sel(sel_q), .tick(tick)
  );

  kwd_counter u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load(cnt_load), .load_val(cnt_val),
    .clr(dog_bite), .cnt(cnt_q), .ovf(ovf)
  );

  kwd_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst(rst), .fire(dog_bite), .pulse(wdog_rst)
  );
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
  parameter int PULSE_LEN = 4,
  parameter int ADDR_W    = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       bus_wdata,
  input logic              wdog_rst,
  input logic              en,
  input logic              rste,
  input logic              flag,
  input logic [7:0]        cnt
);
  int unsigned high_run;

  always_ff @(posedge clk) begin
    if (rst)           high_run <= 0;
    else if (wdog_rst) high_run <= high_run + 1;
    else               high_run <= 0;
  end

  // R9
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wdog_rst) |-> high_run == PULSE_LEN);

  // R9
  pulse_state_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wdog_rst) |-> (flag && !en));

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past(bus_wr && bus_addr == ADDR_W'(4) && bus_wdata == 16'hA500));

  // R4
  rste_write_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rste) |-> $past(bus_wr && bus_addr == ADDR_W'(4) && bus_wdata[15:8] == 8'h5A));

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !(bus_wr && bus_addr == ADDR_W'(2) && bus_wdata[15:8] == 8'h5A)) |=> $stable(cnt));
endmodule

bind keyed_wdog kwd_checker #(.PULSE_LEN(PULSE_LEN), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .wdog_rst(wdog_rst), .en(en_q), .rste(rste_q), .flag(flag_q), .cnt(cnt_q)
);

// File: tb/keyed_wdog_test.sv
module keyed_wdog_test;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE_LEN  = 4;

  logic        clk = 0;
  logic        rst = 1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        wdog_rst;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_wdog #(.SEL_W(3), .MAX_LOG2(14), .PULSE_LEN(PULSE_LEN), .ADDR_W(3)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdog_rst(wdog_rst)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1; bus_addr = 3'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    bus_rd = 1; bus_addr = 3'(a);
    @(negedge clk);
    bus_rd = 0;
    d = int'(bus_rdata);
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // arm, clear, load, enable; return cycles to reset pulse and its width
  task automatic run_dog(input int sel, input int c, input int lim, output int n, output int w);
    int d;
    rd(4, d);
    wr(4, 16'hA500);
    wr(4, 16'h5A40);
    wr(2, 16'h5A00 | c);
    wr(0, 16'hA560 | sel);
    n = 0;
    while (!wdog_rst && n < lim) begin @(posedge clk); #1; n++; end
    w = 0;
    while (wdog_rst && w < 100) begin w++; @(posedge clk); #1; end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: run hung, got 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int d, a, b, n, w, seen;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(0, d); chk("R1 ctrl", d, 0);
    rd(2, d); chk("R1 count", d, 0);
    rd(4, d); chk("R1 rstctl", d, 0);
    chk("R1 wdog_rst", int'(wdog_rst), 0);

    // R3 keyed counter writes
    wr(2, 16'h1234); rd(2, d); chk("R3 bad key", d, 0);
    wr(2, 16'h5A37); rd(2, d); chk("R3 load", d, 16'h0037);
    // R2 keyed control writes
    wr(0, 16'h5A65); rd(0, d); chk("R2 bad key", d, 0);
    wr(0, 16'hA543); rd(0, d); chk("R2 load", d, 16'h0043);
    wr(0, 16'hA500); rd(0, d); chk("R2 clear", d, 0);
    // R4 reset-enable
    wr(4, 16'h1240); rd(4, d); chk("R4 bad key", d, 0);
    wr(4, 16'h5A40); rd(4, d); chk("R4 set", d, 16'h0040);
    wr(4, 16'h5A00); rd(4, d); chk("R4 clr", d, 0);

    // R6 stop holds count
    wr(2, 16'h5A00);
    wr(0, 16'hA520);
    wait_cyc(40);
    wr(0, 16'hA500);
    rd(2, a); wait_cyc(30); rd(2, b);
    chk("R6 hold", b, a);
    chk("R6 counted", int'(a >= 40), 1);

    // R8 mode clear: wraps, no flag, no reset
    wr(4, 16'h5A40);
    wr(2, 16'h5AFA);
    wr(0, 16'hA520);
    seen = 0;
    for (int i = 0; i < 30; i++) begin @(posedge clk); #1; if (wdog_rst) seen = 1; end
    wr(0, 16'hA500);
    chk("R8 no pulse mode0", seen, 0);
    rd(4, d); chk("R8 no flag mode0", d, 16'h0040);

    // R5 R9 sweep of select values and load values
    for (int s = 0; s < 8; s++) begin
      for (int j = 0; j < 3; j++) begin
        int c, exp_n;
        c = (j == 0) ? 255 : (j == 1) ? 253 : 0;
        if (j == 1 && s > 6) continue;
        if (j == 2 && s > 2) continue;
        exp_n = (256 - c) * (1 << (2 * s));
        run_dog(s, c, exp_n + 50, n, w);
        chk($sformatf("R5 latency sel%0d load%0d", s, c), n, exp_n);
        chk("R9 pulse width", w, PULSE_LEN);
        rd(0, d); chk("R9 enable cleared", d, 16'h0040 | s);
        rd(2, d); chk("R9 count cleared", d, 0);
        rd(4, d); chk("R9 flag and rste kept", d, 16'h00C0);
      end
    end

    // R10 read-before-clear
    run_dog(0, 255, 100, n, w);
    wr(4, 16'hA500);
    rd(4, d); chk("R10 clear without read", d, 16'h00C0);
    wr(4, 16'hA501);
    rd(4, d); chk("R10 inexact word", d, 16'h00C0);
    wr(4, 16'hA500);
    rd(4, d); chk("R10 clear after read", d, 16'h0040);
    run_dog(0, 255, 100, n, w);
    rd(4, d);
    wr(4, 16'hA500);
    wr(2, 16'h5A00);
    wr(0, 16'hA560);
    wait_cyc(300);
    wr(4, 16'hA500);
    rd(4, d); chk("R10 arming spent", d, 16'h00C0);
    wr(4, 16'hA500);
    rd(4, d); chk("R10 rearmed clear", d, 16'h0040);

    // R8 mode set, reset disabled: flag only, timer keeps running
    wr(4, 16'h5A00);
    wr(2, 16'h5AF0);
    wr(0, 16'hA560);
    seen = 0;
    for (int i = 0; i < 40; i++) begin @(posedge clk); #1; if (wdog_rst) seen = 1; end
    chk("R8 no pulse without rste", seen, 0);
    rd(4, d); chk("R8 flag set mode1", d, 16'h0080);
    rd(0, d); chk("R8 still enabled", d, 16'h0060);
    wr(0, 16'hA500);
    wr(4, 16'hA500);

    // R7 keepalive: sel1 divides by 4, full interval 1024 clocks
    wr(4, 16'h5A40);
    wr(2, 16'h5A00);
    wr(0, 16'hA561);
    seen = 0;
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 500; i++) begin @(posedge clk); #1; if (wdog_rst) seen = 1; end
      wr(2, 16'h5A00);
    end
    chk("R7 kicks hold off reset", seen, 0);
    rd(0, d); chk("R7 still enabled", d, 16'h0061);
    wr(0, 16'hA500);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule